// File: doc/BRIEF.md
# TX Front-End Power Sequencer

This block sequences the control pins of a radio front end around each transmission. Four pins follow every transmit: the transmit enable, the power-amplifier enable, the transmit/receive switch and a secondary power enable. The MAC transmit logic signals the start of a transmission with a one-cycle `tx_start` pulse. It signals the end of its internal transmit data with a one-cycle `tx_data_end` pulse. The transmit enable goes high straight away. Each of the other three pins goes high after its own programmed number of microseconds. After the data-end pulse, each of the four pins goes low after its own separate delay.

A microsecond tick is derived from a programmable count of system clocks. The same tick clocks a power-up hold counted in 2 ms units (2000 ticks each). Until that hold expires, every output stays low: the four transmit pins and the three supply-side outputs (primary enable, radio enable and the active-low PHY reset). The three supply-side outputs then go high together and stay high.

An override-select input hands the four transmit pins to a direct pin-value input, for bring-up and calibration.

Top module: `fe_tx_sequencer`

## Requirements
- R1: During reset, and until the power-up hold expires, all seven outputs are low. Let W be `cfg_pwrup_dly`, P the tick period and T = max(W*2000, 1). `pe1_o`, `radio_o` and `phy_rstn_o` rise together on the clock edge that ends tick T, which is edge T*P after reset release. From then on they stay high.
- R2: The tick period P equals `cfg_clks_per_us` system clocks, with a value of 0 treated as 1. The divider restarts at every accepted transmit start and at every accepted data end. The first tick after such an event therefore falls P clocks later.
- R3: An accepted `tx_start` sampled at edge E0 drives `txen_o` high after edge E0.
- R4: `pa_o`, `trsw_o` and `pe2_o` each rise at edge E0+(d+1)*P, where d is that pin's 4-bit rise delay. A delay of 0 therefore means the next tick.
- R5: After an accepted `tx_data_end` sampled at edge F0, each pin that is high falls at edge F0+(f+1)*P. This applies to all four pins, `txen_o` included, and f is that pin's own 4-bit fall delay.
- R6: A pin whose rise is still pending when the data end is accepted never rises in that transmission. This also holds when its rise tick lands on the very edge where the data end is sampled.
- R7: `tx_start` is ignored before the power-up hold expires, while override is selected, and while any transmit pin is high or pending from the previous transmission.
- R8: After a data end has been accepted, further `tx_data_end` pulses are ignored until the next accepted start. The fall timing set by the first data end is unchanged.
- R9: Once powered up, a high `ovr_sel` makes the four pins follow `ovr_pins` from the next edge. The bit mapping is bit 0 `txen_o`, bit 1 `pa_o`, bit 2 `trsw_o`, bit 3 `pe2_o`. Selecting override aborts any running sequence. After release, all four pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clks_per_us | input | 6 | System clocks per microsecond tick (0 acts as 1) |
| cfg_pwrup_dly | input | 4 | Power-up hold in 2 ms units |
| cfg_rise_pa | input | 4 | Power-amplifier enable rise delay, us |
| cfg_rise_trsw | input | 4 | Transmit/receive switch rise delay, us |
| cfg_rise_pe2 | input | 4 | Secondary power enable rise delay, us |
| cfg_fall_txen | input | 4 | Transmit enable fall delay, us |
| cfg_fall_pa | input | 4 | Power-amplifier enable fall delay, us |
| cfg_fall_trsw | input | 4 | Transmit/receive switch fall delay, us |
| cfg_fall_pe2 | input | 4 | Secondary power enable fall delay, us |
| tx_start | input | 1 | One-cycle pulse: transmission begins |
| tx_data_end | input | 1 | One-cycle pulse: internal transmit data finished |
| ovr_sel | input | 1 | Direct pin control select |
| ovr_pins | input | 4 | Direct pin values: bit 0 txen, 1 pa, 2 trsw, 3 pe2 |
| txen_o | output | 1 | Transmit enable |
| pa_o | output | 1 | Power-amplifier enable |
| trsw_o | output | 1 | Transmit/receive switch |
| pe2_o | output | 1 | Secondary power enable |
| pe1_o | output | 1 | Primary enable, high after power-up hold |
| radio_o | output | 1 | Radio enable, high after power-up hold |
| phy_rstn_o | output | 1 | Active-low PHY reset, released after power-up hold |

## Verification
The data end and a pin's rise tick can fall on the same clock edge. The data end must win, so that pin stays low for the whole transmission. The bench provokes this by choosing the gap between the start and data-end pulses to be exactly (d+1)*P for the power-amplifier enable. At the same time, other pins with shorter and longer rise delays act as controls on either side of the collision. The bench judges every cycle of the rise and fall windows against expected values derived from R4 to R6. A second collision, a stray data end landing between ticks during the fall phase, is judged by whether the power-amplifier enable still falls on its original edge.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RISE = 2'd1,
        CH_ON   = 2'd2,
        CH_FALL = 2'd3
    } ch_state_e;

    localparam int NUM_FE_PINS = 4;
    localparam int PIN_TXEN    = 0;
    localparam int PIN_PA      = 1;
    localparam int PIN_TRSW    = 2;
    localparam int PIN_PE2     = 3;

endpackage

// File: rtl/fe_seq_tick.sv
module fe_seq_tick #(
    parameter int DIV_W      = 6,
    parameter int PWR_W      = 4,
    parameter int UNIT_TICKS = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [PWR_W-1:0] cfg_pwrup,
    input  logic             restart,
    output logic             tick,
    output logic             ready
);

    localparam int MAX_TICKS = ((1 << PWR_W) - 1) * UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] us;
        logic             rdy;
    } tick_t;

    tick_t q, d;
    logic [DIV_W-1:0] period_m1;
    logic [CNT_W:0]   target;
    logic [CNT_W:0]   us_next;

    always_comb begin
        period_m1 = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
        tick      = (q.div >= period_m1);
        target    = (CNT_W+1)'(cfg_pwrup) * (CNT_W+1)'(UNIT_TICKS);
        if (target == '0) begin
            target = (CNT_W+1)'(1);
        end
        us_next = {1'b0, q.us} + 1'b1;

        d = q;
        if (restart || tick) begin
            d.div = '0;
        end else begin
            d.div = q.div + 1'b1;
        end
        if (tick && !q.rdy) begin
            if (us_next >= target) begin
                d.rdy = 1'b1;
            end else begin
                d.us = us_next[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready = q.rdy;

    // R1: the power-up state, once reached, is never left
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> q.rdy);

    // R2: a restart always brings the divider back to zero
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.div == '0));

endmodule

// File: rtl/fe_seq_chan.sv
module fe_seq_chan
    import fe_seq_pkg::*;
#(
    parameter int DLY_W     = 4,
    parameter bit IMMEDIATE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             abort,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             pin,
    output logic             idle
);

    typedef struct packed {
        ch_state_e        st;
        logic [DLY_W-1:0] cnt;
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        if (abort) begin
            d.st  = CH_OFF;
            d.cnt = '0;
        end else if (start) begin
            d.st  = IMMEDIATE ? CH_ON : CH_RISE;
            d.cnt = rise_dly;
        end else if (stop) begin
            // a pending rise is cancelled; a high pin begins its fall delay
            if (q.st == CH_RISE) begin
                d.st  = CH_OFF;
                d.cnt = '0;
            end else if (q.st == CH_ON) begin
                d.st  = CH_FALL;
                d.cnt = fall_dly;
            end
        end else if (tick) begin
            case (q.st)
                CH_RISE: begin
                    if (q.cnt == '0) d.st = CH_ON;
                    else             d.cnt = q.cnt - 1'b1;
                end
                CH_FALL: begin
                    if (q.cnt == '0) d.st = CH_OFF;
                    else             d.cnt = q.cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CH_OFF, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign pin  = (q.st == CH_ON) || (q.st == CH_FALL);
    assign idle = (q.st == CH_OFF);

    // R7: the top only launches a channel that has fully returned to rest
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == CH_OFF));

    // R4: a pin goes high only through a start or a tick
    a_r4_rise_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin) |-> $past(tick || start));

    // R5: a pin goes low only through a tick or an abort
    a_r5_fall_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin) |-> $past(tick || abort));

endmodule

// File: rtl/fe_tx_sequencer.sv
module fe_tx_sequencer
    import fe_seq_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter int DLY_W      = 4,
    parameter int PWR_W      = 4,
    parameter int UNIT_TICKS = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_clks_per_us,
    input  logic [PWR_W-1:0] cfg_pwrup_dly,
    input  logic [DLY_W-1:0] cfg_rise_pa,
    input  logic [DLY_W-1:0] cfg_rise_trsw,
    input  logic [DLY_W-1:0] cfg_rise_pe2,
    input  logic [DLY_W-1:0] cfg_fall_txen,
    input  logic [DLY_W-1:0] cfg_fall_pa,
    input  logic [DLY_W-1:0] cfg_fall_trsw,
    input  logic [DLY_W-1:0] cfg_fall_pe2,
    input  logic             tx_start,
    input  logic             tx_data_end,
    input  logic             ovr_sel,
    input  logic [3:0]       ovr_pins,
    output logic             txen_o,
    output logic             pa_o,
    output logic             trsw_o,
    output logic             pe2_o,
    output logic             pe1_o,
    output logic             radio_o,
    output logic             phy_rstn_o
);

    localparam int NP = NUM_FE_PINS;

    typedef struct packed {
        logic          tx_active;
        logic          ovr;
        logic [NP-1:0] ovr_val;
    } top_t;

    top_t q, d;

    logic             tick;
    logic             ready;
    logic             start_acc;
    logic             stop_acc;
    logic             abort;
    logic [NP-1:0]    chan_pin;
    logic [NP-1:0]    chan_idle;
    logic [NP-1:0]    pins_out;
    logic [DLY_W-1:0] rise_v [NP];
    logic [DLY_W-1:0] fall_v [NP];

    assign rise_v[PIN_TXEN] = '0;
    assign rise_v[PIN_PA]   = cfg_rise_pa;
    assign rise_v[PIN_TRSW] = cfg_rise_trsw;
    assign rise_v[PIN_PE2]  = cfg_rise_pe2;
    assign fall_v[PIN_TXEN] = cfg_fall_txen;
    assign fall_v[PIN_PA]   = cfg_fall_pa;
    assign fall_v[PIN_TRSW] = cfg_fall_trsw;
    assign fall_v[PIN_PE2]  = cfg_fall_pe2;

    always_comb begin
        abort     = ovr_sel || !ready;
        start_acc = tx_start && !abort && (&chan_idle) && !q.tx_active;
        stop_acc  = tx_data_end && !abort && q.tx_active;

        d         = q;
        d.ovr     = ovr_sel;
        d.ovr_val = ovr_pins;
        if (abort) begin
            d.tx_active = 1'b0;
        end else if (start_acc) begin
            d.tx_active = 1'b1;
        end else if (stop_acc) begin
            d.tx_active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    fe_seq_tick #(
        .DIV_W      (DIV_W),
        .PWR_W      (PWR_W),
        .UNIT_TICKS (UNIT_TICKS)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_clks_per_us),
        .cfg_pwrup (cfg_pwrup_dly),
        .restart   (start_acc || stop_acc),
        .tick      (tick),
        .ready     (ready)
    );

    for (genvar i = 0; i < NP; i++) begin : g_chan
        fe_seq_chan #(
            .DLY_W     (DLY_W),
            .IMMEDIATE (i == PIN_TXEN)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .start    (start_acc),
            .stop     (stop_acc),
            .abort    (abort),
            .rise_dly (rise_v[i]),
            .fall_dly (fall_v[i]),
            .pin      (chan_pin[i]),
            .idle     (chan_idle[i])
        );
    end

    always_comb begin
        if (!ready)     pins_out = '0;
        else if (q.ovr) pins_out = q.ovr_val;
        else            pins_out = chan_pin;
    end

    assign txen_o     = pins_out[PIN_TXEN];
    assign pa_o       = pins_out[PIN_PA];
    assign trsw_o     = pins_out[PIN_TRSW];
    assign pe2_o      = pins_out[PIN_PE2];
    assign pe1_o      = ready;
    assign radio_o    = ready;
    assign phy_rstn_o = ready;

    // R3: an accepted start shows on the transmit enable one edge later
    a_r3_start_raises_txen: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> txen_o);

    // R9: an override selection sampled at an edge drives the pins after it
    a_r9_override_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_sel && ready) |=> (pins_out == $past(ovr_pins)));

    // R8: a data end is only taken while a transmission is open
    a_r8_stop_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        stop_acc |=> !q.tx_active);

endmodule

// File: tb/fe_tx_sequencer_bench.sv
module fe_tx_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_clks_per_us = 6'd3;
    logic [3:0] cfg_pwrup_dly = 4'd0;
    logic [3:0] cfg_rise_pa = '0, cfg_rise_trsw = '0, cfg_rise_pe2 = '0;
    logic [3:0] cfg_fall_txen = '0, cfg_fall_pa = '0, cfg_fall_trsw = '0, cfg_fall_pe2 = '0;
    logic       tx_start = 1'b0;
    logic       tx_data_end = 1'b0;
    logic       ovr_sel = 1'b0;
    logic [3:0] ovr_pins = '0;
    logic txen_o, pa_o, trsw_o, pe2_o, pe1_o, radio_o, phy_rstn_o;

    int n_checks = 0;
    int n_fail = 0;
    int per = 3;
    int rise_c [4];
    int fall_c [4];

    always #10 clk = ~clk;

    fe_tx_sequencer u_fe_tx_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_clks_per_us(cfg_clks_per_us), .cfg_pwrup_dly(cfg_pwrup_dly),
        .cfg_rise_pa(cfg_rise_pa), .cfg_rise_trsw(cfg_rise_trsw), .cfg_rise_pe2(cfg_rise_pe2),
        .cfg_fall_txen(cfg_fall_txen), .cfg_fall_pa(cfg_fall_pa),
        .cfg_fall_trsw(cfg_fall_trsw), .cfg_fall_pe2(cfg_fall_pe2),
        .tx_start(tx_start), .tx_data_end(tx_data_end),
        .ovr_sel(ovr_sel), .ovr_pins(ovr_pins),
        .txen_o(txen_o), .pa_o(pa_o), .trsw_o(trsw_o), .pe2_o(pe2_o),
        .pe1_o(pe1_o), .radio_o(radio_o), .phy_rstn_o(phy_rstn_o)
    );

    function automatic logic [3:0] tx_pins();
        return {pe2_o, trsw_o, pa_o, txen_o};
    endfunction

    function automatic logic [2:0] pwr_pins();
        return {pe1_o, radio_o, phy_rstn_o};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int p, input int r1, input int r2, input int r3,
                           input int f0, input int f1, input int f2, input int f3);
        per = p;
        cfg_clks_per_us = (p == 1) ? 6'd0 : 6'(p);
        rise_c[0] = -1; rise_c[1] = r1; rise_c[2] = r2; rise_c[3] = r3;
        fall_c[0] = f0; fall_c[1] = f1; fall_c[2] = f2; fall_c[3] = f3;
        cfg_rise_pa = 4'(r1); cfg_rise_trsw = 4'(r2); cfg_rise_pe2 = 4'(r3);
        cfg_fall_txen = 4'(f0); cfg_fall_pa = 4'(f1);
        cfg_fall_trsw = 4'(f2); cfg_fall_pe2 = 4'(f3);
    endtask

    function automatic logic [3:0] exp_rise(input int k);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) e[i] = (k >= (rise_c[i] + 1) * per);
        return e;
    endfunction

    function automatic logic [3:0] exp_fall(input int k, input int s);
        logic [3:0] e;
        for (int i = 0; i < 4; i++)
            e[i] = ((rise_c[i] + 1) * per <= s - 1) && (k < (fall_c[i] + 1) * per);
        return e;
    endfunction

    task automatic pulse_start();
        @(negedge clk) tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
    endtask

    task automatic pulse_end();
        tx_data_end = 1'b1;
        @(negedge clk) tx_data_end = 1'b0;
    endtask

    // full transmission: every cycle of the rise and fall windows is judged
    task automatic run_tx(input int gap, input int tail, input string tag);
        pulse_start();
        for (int k = 0; k < gap; k++) begin
            if (k > 0) @(negedge clk);
            chk({tag, " rise R3 R4"}, {3'b0, tx_pins()}, {3'b0, exp_rise(k)});
        end
        pulse_end();
        for (int k = 0; k < tail; k++) begin
            if (k > 0) @(negedge clk);
            chk({tag, " fall R5 R6"}, {3'b0, tx_pins()}, {3'b0, exp_fall(k, gap)});
        end
    endtask

    task automatic test_reset_long();
        rst_n = 1'b0;
        set_cfg(2, 0, 0, 0, 0, 0, 0, 0);
        cfg_pwrup_dly = 4'd1;
        repeat (3) @(negedge clk);
        chk("R1 outputs low in reset", {pwr_pins(), tx_pins()}, 7'b0);
        rst_n = 1'b1;
        tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        chk("R7 start before power-up", {3'b0, tx_pins()}, 7'b0);
        repeat (3998) @(negedge clk);
        chk("R1 hold edge 3999", {pwr_pins(), tx_pins()}, 7'b0);
        @(negedge clk);
        chk("R1 ready edge 4000", {pwr_pins(), tx_pins()}, {3'b111, 4'b0});
        repeat (3) @(negedge clk);
        chk("R7 early start not latched", {3'b0, tx_pins()}, 7'b0);
    endtask

    task automatic test_reset_short();
        @(negedge clk) rst_n = 1'b0;
        set_cfg(3, 0, 0, 0, 0, 0, 0, 0);
        cfg_pwrup_dly = 4'd0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 zero hold edge 2", {pwr_pins(), tx_pins()}, 7'b0);
        @(negedge clk);
        chk("R1 zero hold edge 3", {pwr_pins(), tx_pins()}, {3'b111, 4'b0});
    endtask

    task automatic test_basic();
        set_cfg(3, 1, 2, 0, 1, 0, 3, 2);
        run_tx(12, 14, "basic P3");
        chk("R5 idle after basic", {pwr_pins(), tx_pins()}, {3'b111, 4'b0});
    endtask

    task automatic test_collision();
        // pa rise tick lands on the data-end edge: data end wins (R6)
        set_cfg(3, 3, 0, 5, 2, 1, 1, 0);
        run_tx(12, 12, "collision R6");
    endtask

    task automatic test_fast_tick();
        // clks setting 0 acts as one clock per tick (R2)
        set_cfg(1, 2, 7, 15, 15, 0, 4, 9);
        run_tx(20, 20, "period0 R2");
        set_cfg(5, 0, 1, 2, 0, 2, 1, 0);
        run_tx(17, 17, "period5 R2");
    endtask

    task automatic test_busy_and_stray_end();
        set_cfg(2, 0, 15, 15, 0, 5, 0, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R4 pa high before end", {6'b0, pa_o}, 7'd1);
        pulse_end();
        repeat (3) @(negedge clk);
        chk("R5 txen fell", {3'b0, tx_pins()}, {3'b0, 4'b0010});
        tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        chk("R7 start while pa high", {3'b0, tx_pins()}, {3'b0, 4'b0010});
        pulse_end();
        repeat (6) @(negedge clk);
        chk("R8 pa still high edge 11", {6'b0, pa_o}, 7'd1);
        @(negedge clk);
        chk("R8 pa falls edge 12", {3'b0, tx_pins()}, 7'b0);
        pulse_start();
        chk("R7 start accepted when idle", {3'b0, tx_pins()}, {3'b0, 4'b0001});
        @(negedge clk);
        pulse_end();
        repeat (4) @(negedge clk);
        chk("R5 cleanup idle", {3'b0, tx_pins()}, 7'b0);
    endtask

    task automatic test_override();
        set_cfg(2, 0, 1, 2, 0, 0, 0, 0);
        @(negedge clk) begin ovr_sel = 1'b1; ovr_pins = 4'b1010; end
        @(negedge clk);
        chk("R9 override drives pins", {pwr_pins(), tx_pins()}, {3'b111, 4'b1010});
        pulse_start();
        ovr_pins = 4'b0101;
        @(negedge clk);
        chk("R9 override new value", {3'b0, tx_pins()}, {3'b0, 4'b0101});
        ovr_sel = 1'b0;
        @(negedge clk);
        chk("R9 release all low", {3'b0, tx_pins()}, 7'b0);
        repeat (8) @(negedge clk);
        chk("R7 start under override ignored", {3'b0, tx_pins()}, 7'b0);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R4 pa up before abort", {3'b0, tx_pins()}, {3'b0, 4'b0011});
        ovr_sel = 1'b1; ovr_pins = 4'b0000;
        @(negedge clk);
        chk("R9 abort to override", {3'b0, tx_pins()}, 7'b0);
        ovr_sel = 1'b0;
        repeat (12) @(negedge clk);
        chk("R9 aborted sequence stays low", {3'b0, tx_pins()}, 7'b0);
        pulse_start();
        chk("R7 start after abort", {3'b0, tx_pins()}, {3'b0, 4'b0001});
        pulse_end();
        repeat (4) @(negedge clk);
        chk("R5 override cleanup", {3'b0, tx_pins()}, 7'b0);
    endtask

    initial begin
        fork
            begin
                test_reset_long();
                test_reset_short();
                test_basic();
                test_collision();
                test_fast_tick();
                test_busy_and_stray_end();
                test_override();
            end
            begin
                repeat (190000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule